// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator

This block drives the six gate signals of a three-phase voltage-source inverter. A triangular counter rises from zero to the programmed half period and falls back. Each output turns on or off where the counter crosses a threshold worked out from that phase's duty word. Because of this, every pulse sits symmetrically about the middle of the period. In each phase pair the high-side rising edge is held back by a programmable dead time. Any pulse shorter than a programmable minimum width is dropped. The edge resolution is one clock.

A host programs the generator through a plain write port. Timing words go into shadow registers and are copied to the active set when a period starts. In double-rate mode the duty, dead-time and minimum-width words are also copied at the midpoint of the period. Further controls are a per-output enable mask, optional high-frequency chopping of the high-side and low-side groups (for transformer-coupled drivers), a polarity pin, and an active-low trip input. The trip input blanks all six outputs at once, with no clock involved. The block then holds them blanked until the host writes the trip-clear address. A one-cycle sync pulse marks the start of each period.

Top module: `pwm3_gen`

## Requirements
- R1: While reset is asserted and right after it, every gate output is at its inactive level (enable mask cleared). The first sync pulse appears one clock after reset is released.
- R2: The counter value `H` comes from the half-period register (address 0); a written 0 is used as 1. The counter visits 0..H-1 going up and then H-1..0 going down. Sync pulses, each one clock wide, are therefore 2*H clocks apart.
- R3: Duty registers sit at address 1 (phase A), 2 (B) and 3 (C). Define D = min(duty, H) and S = H - D. The high-side output of a phase is on while the counter is at least S + dead time (dead time at address 4). Measured from the sync clock, the high side first turns on at offset S + dead and stays on for 2*(H - S - dead) clocks per period, and for none if that is not positive.
- R4: The low-side output of a phase is on while the counter is below S. It therefore covers the first S and the last S clocks of each period.
- R5: The two outputs of a phase are never on together. At every switching point they are separated by exactly the dead time.
- R6: If a half-period pulse is shorter than the minimum width (address 5), that output stays off for the whole half. A minimum width of 0 turns this deletion off.
- R7: In single-rate mode (address 6 bit 0 = 0), a value written into the half-period, duty, dead-time or minimum-width register has no effect until the next period start.
- R8: In double-rate mode (address 6 bit 0 = 1), a duty write made during the rising half also takes effect at that period's midpoint. The half-period word still changes only at a period start.
- R9: The enable mask (address 8) has one bit per output: bit 2p is the high side and bit 2p+1 the low side of phase p, with A=0, B=1, C=2. A cleared bit holds its output inactive. The gate output vector uses the same bit order.
- R10: With the polarity input at 1 an active output drives 1. With it at 0 an active output drives 0 and an inactive output drives 1.
- R11: A low level on the trip input drives all six outputs to their inactive level in the same clock cycle, with no clock edge needed.
- R12: A trip stays latched after the trip input returns high. A write to address 9 clears it. Writes to address 9 made while the trip input is still low are ignored.
- R13: When chopping is enabled (address 6 bit 1 for the high sides, bit 2 for the low sides), the chosen outputs are ANDed with a carrier that restarts at each period start. The carrier is on for N+1 clocks and then off for N+1 clocks, where N is stored at address 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register write address |
| wrData | input | 16 | Register write data |
| tripN | input | 1 | Active-low shutdown input, asynchronous |
| polHigh | input | 1 | 1 = outputs active high, 0 = active low |
| gateOut | output | 6 | Gate drives {CL,CH,BL,BH,AL,AH} |
| syncOut | output | 1 | One-clock pulse at each period start |

## Verification
Several properties are checked on every cycle: the two outputs of a phase are never on together, the counter stays inside the active half period, the half period changes only at a wrap, sync pulses are one clock wide, and a trip latches and holds until a clear is written. Other behaviour can only be shown by the bench's scenarios. These include the exact edge offsets and on-times for plain, clipped and deleted pulses, the difference between single-rate and double-rate reloading for a write made inside a period, the mask and polarity mappings, the chopping pattern, and the clock-free blanking on a trip.

// File: rtl/pwm3_pkg.sv
`timescale 1ns/1ps
package pwm3_pkg;

  localparam int unsigned NUM_PHASES = 3;
  localparam int unsigned NUM_OUTS   = 2 * NUM_PHASES;

  typedef enum logic [3:0] {
    REG_HALF    = 4'd0,
    REG_DUTY_A  = 4'd1,
    REG_DUTY_B  = 4'd2,
    REG_DUTY_C  = 4'd3,
    REG_DEAD    = 4'd4,
    REG_MINP    = 4'd5,
    REG_MODE    = 4'd6,
    REG_CHOP    = 4'd7,
    REG_MASK    = 4'd8,
    REG_TRIPCLR = 4'd9
  } regAddr_e;

  // Strobes sent from control to datapath
  typedef struct packed {
    logic periodStart;   // counter sits at the first clock of a period
    logic wrapTurn;      // last clock of a period; next clock starts a new one
  } pwmStrobes_t;

endpackage

// File: rtl/pwm3_ctrl.sv
`timescale 1ns/1ps
module pwm3_ctrl
  import pwm3_pkg::*;
#(
  parameter int unsigned    W          = 16,
  parameter logic [W-1:0]   RESET_HALF = 8
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               wrEn,
  input  logic [3:0]                         wrAddr,
  input  logic [W-1:0]                       wrData,
  input  logic                               tripN,
  output logic [W-1:0]                       cnt,
  output logic [W-1:0]                       halfEff,
  output pwmStrobes_t                        strobes,
  output logic [NUM_PHASES-1:0][W-1:0]       duty,
  output logic [W-1:0]                       dead,
  output logic [W-1:0]                       minPulse,
  output logic                               chopHiEn,
  output logic                               chopLoEn,
  output logic [W-1:0]                       chopDiv,
  output logic [NUM_OUTS-1:0]                outMask,
  output logic                               tripLatched
);

  localparam logic [W-1:0] ONE = 1;

  logic [W-1:0]                 shHalf, shDead, shMin, actHalf;
  logic [NUM_PHASES-1:0][W-1:0] shDuty;
  logic                         doubleMode;
  logic                         upPhase;
  logic                         midTurn, wrapTurn;
  logic [1:0]                   tripSync;
  logic                         clearWrite;

  assign halfEff  = (actHalf == '0) ? ONE : actHalf;
  assign midTurn  = upPhase  && (cnt == halfEff - ONE);
  assign wrapTurn = !upPhase && (cnt == '0);

  assign strobes.periodStart = upPhase && (cnt == '0);
  assign strobes.wrapTurn    = wrapTurn;

  assign clearWrite = wrEn && (wrAddr == REG_TRIPCLR);

  // Shadow registers and immediate controls
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shHalf     <= RESET_HALF;
      shDuty     <= '0;
      shDead     <= '0;
      shMin      <= '0;
      doubleMode <= 1'b0;
      chopHiEn   <= 1'b0;
      chopLoEn   <= 1'b0;
      chopDiv    <= '0;
      outMask    <= '0;
    end else if (wrEn) begin
      for (int p = 0; p < NUM_PHASES; p++) begin
        if (wrAddr == 4'(REG_DUTY_A) + 4'(p)) shDuty[p] <= wrData;
      end
      case (wrAddr)
        REG_HALF: shHalf <= wrData;
        REG_DEAD: shDead <= wrData;
        REG_MINP: shMin  <= wrData;
        REG_MODE: begin
          doubleMode <= wrData[0];
          chopHiEn   <= wrData[1];
          chopLoEn   <= wrData[2];
        end
        REG_CHOP: chopDiv <= wrData;
        REG_MASK: outMask <= wrData[NUM_OUTS-1:0];
        default: ;
      endcase
    end
  end

  // Active register set: full reload at wrap, timing-only reload at midpoint
  always_ff @(posedge clk) begin
    if (!rstN) begin
      actHalf  <= RESET_HALF;
      duty     <= '0;
      dead     <= '0;
      minPulse <= '0;
    end else if (wrapTurn) begin
      actHalf  <= shHalf;
      duty     <= shDuty;
      dead     <= shDead;
      minPulse <= shMin;
    end else if (midTurn && doubleMode) begin
      duty     <= shDuty;
      dead     <= shDead;
      minPulse <= shMin;
    end
  end

  // Up/down counter, each turning value held for two clocks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      upPhase <= 1'b1;
    end else if (wrapTurn) begin
      upPhase <= 1'b1;
    end else if (midTurn) begin
      upPhase <= 1'b0;
    end else if (upPhase) begin
      cnt <= cnt + ONE;
    end else begin
      cnt <= cnt - ONE;
    end
  end

  // Trip synchronizer and latch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tripSync    <= 2'b11;
      tripLatched <= 1'b0;
    end else begin
      tripSync <= {tripSync[0], tripN};
      if (!tripSync[1])    tripLatched <= 1'b1;
      else if (clearWrite) tripLatched <= 1'b0;
    end
  end

  // R2: counter never leaves the active half period
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rstN)
    cnt < halfEff);

  // R7: the half period changes only across a wrap
  a_r7_half_holds: assert property (@(posedge clk) disable iff (!rstN)
    !wrapTurn |=> $stable(actHalf));

  // R12: a low synchronized trip latches
  a_r12_trip_sets: assert property (@(posedge clk) disable iff (!rstN)
    !tripSync[1] |=> tripLatched);

  // R12: the latch holds until a clear write
  a_r12_trip_holds: assert property (@(posedge clk) disable iff (!rstN)
    (tripLatched && !clearWrite) |=> tripLatched);

endmodule

// File: rtl/pwm3_datapath.sv
`timescale 1ns/1ps
module pwm3_datapath
  import pwm3_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  pwmStrobes_t                   strobes,
  input  logic [W-1:0]                  cnt,
  input  logic [W-1:0]                  halfEff,
  input  logic [NUM_PHASES-1:0][W-1:0]  duty,
  input  logic [W-1:0]                  dead,
  input  logic [W-1:0]                  minPulse,
  input  logic                          chopHiEn,
  input  logic                          chopLoEn,
  input  logic [W-1:0]                  chopDiv,
  input  logic [NUM_OUTS-1:0]           outMask,
  input  logic                          tripLatched,
  input  logic                          tripN,
  input  logic                          polHigh,
  output logic [NUM_OUTS-1:0]           gateOut,
  output logic                          syncOut
);

  localparam int unsigned XW = W + 1;

  logic [XW-1:0]       halfX, cntX, chopCnt;
  logic                carrier, chopLast, tripOff;
  logic [NUM_OUTS-1:0] gateNext, gateReg, onLevel;
  logic                syncReg;

  assign halfX = {1'b0, halfEff};
  assign cntX  = {1'b0, cnt};

  // Chopping carrier, restarted at every period
  assign chopLast = (chopCnt == {chopDiv, 1'b1});
  assign carrier  = (chopCnt <= {1'b0, chopDiv});

  always_ff @(posedge clk) begin
    if (!rstN)                 chopCnt <= '0;
    else if (strobes.wrapTurn) chopCnt <= '0;
    else if (chopLast)         chopCnt <= '0;
    else                       chopCnt <= chopCnt + XW'(1);
  end

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
    logic [XW-1:0] dutyX, dutyClip, swPt, hiTh, hiLen;
    logic          hiKeep, loKeep, hiNow, loNow;

    assign dutyX    = {1'b0, duty[p]};
    assign dutyClip = (dutyX > halfX) ? halfX : dutyX;
    assign swPt     = halfX - dutyClip;
    assign hiTh     = swPt + {1'b0, dead};
    assign hiLen    = (hiTh >= halfX) ? '0 : (halfX - hiTh);
    assign hiKeep   = (hiLen != '0) && (hiLen >= {1'b0, minPulse});
    assign loKeep   = (swPt  != '0) && (swPt  >= {1'b0, minPulse});
    assign hiNow    = hiKeep && (cntX >= hiTh);
    assign loNow    = loKeep && (cntX <  swPt);

    assign gateNext[2*p]   = hiNow && (!chopHiEn || carrier) && outMask[2*p];
    assign gateNext[2*p+1] = loNow && (!chopLoEn || carrier) && outMask[2*p+1];

    // R5: complementary pair never on together
    a_r5_pair_exclusive: assert property (@(posedge clk) disable iff (!rstN)
      !(gateReg[2*p] && gateReg[2*p+1]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gateReg <= '0;
      syncReg <= 1'b0;
    end else begin
      gateReg <= gateNext;
      syncReg <= strobes.periodStart;
    end
  end

  // Trip blanking bypasses the clock
  assign tripOff = !tripN || tripLatched;
  assign onLevel = tripOff ? '0 : gateReg;
  assign gateOut = polHigh ? onLevel : ~onLevel;
  assign syncOut = syncReg;

  // R2: sync pulse lasts one clock
  a_r2_sync_single: assert property (@(posedge clk) disable iff (!rstN)
    syncReg |=> !syncReg);

endmodule

// File: rtl/pwm3_gen.sv
`timescale 1ns/1ps
module pwm3_gen
  import pwm3_pkg::*;
#(
  parameter int unsigned  W          = 16,
  parameter logic [W-1:0] RESET_HALF = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [3:0]    wrAddr,
  input  logic [W-1:0]  wrData,
  input  logic          tripN,
  input  logic          polHigh,
  output logic [5:0]    gateOut,
  output logic          syncOut
);

  pwmStrobes_t                  strobes;
  logic [W-1:0]                 cnt, halfEff, dead, minPulse, chopDiv;
  logic [NUM_PHASES-1:0][W-1:0] duty;
  logic                         chopHiEn, chopLoEn, tripLatched;
  logic [NUM_OUTS-1:0]          outMask;

  pwm3_ctrl #(.W(W), .RESET_HALF(RESET_HALF)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .tripN       (tripN),
    .cnt         (cnt),
    .halfEff     (halfEff),
    .strobes     (strobes),
    .duty        (duty),
    .dead        (dead),
    .minPulse    (minPulse),
    .chopHiEn    (chopHiEn),
    .chopLoEn    (chopLoEn),
    .chopDiv     (chopDiv),
    .outMask     (outMask),
    .tripLatched (tripLatched)
  );

  pwm3_datapath #(.W(W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .cnt         (cnt),
    .halfEff     (halfEff),
    .duty        (duty),
    .dead        (dead),
    .minPulse    (minPulse),
    .chopHiEn    (chopHiEn),
    .chopLoEn    (chopLoEn),
    .chopDiv     (chopDiv),
    .outMask     (outMask),
    .tripLatched (tripLatched),
    .tripN       (tripN),
    .polHigh     (polHigh),
    .gateOut     (gateOut),
    .syncOut     (syncOut)
  );

endmodule

// File: tb/pwm3_gen_bench.sv
`timescale 1ns/1ps
module pwm3_gen_bench;

  logic        clk = 1'b0;
  logic        rstN, wrEn, tripN, polHigh;
  logic [3:0]  wrAddr;
  logic [15:0] wrData;
  logic [5:0]  gateOut;
  logic        syncOut;

  always #2.5 clk = ~clk;

  pwm3_gen u_pwm3_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .tripN(tripN), .polHigh(polHigh), .gateOut(gateOut), .syncOut(syncOut)
  );

  int testsRun = 0, testsFailed = 0, doneCnt = 0;

  typedef struct {
    string tag;
    int    len;
    int    onCnt[6];
    int    firstOn[6];
  } expItem_t;
  expItem_t expQ[$];

  // model configuration (mirrors what the bench wrote)
  int cH = 8, cDead = 0, cMin = 0, cDiv = 0;
  bit cChopHi = 0, cChopLo = 0;
  logic [5:0] cMask = '0;
  int dUp[3] = '{0, 0, 0};
  int dDn[3] = '{0, 0, 0};

  task automatic check(bit ok, string req, string what, int act, int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit refOn(int j, int k);
    int h, c, p, du, s, th, len, span;
    bit up, val, chop;
    h  = (cH == 0) ? 1 : cH;
    up = (k < h);
    c  = up ? k : 2*h - 1 - k;
    p  = j / 2;
    du = up ? dUp[p] : dDn[p];
    if (du > h) du = h;
    s  = h - du;
    span = 2 * (cDiv + 1);
    if (j % 2 == 0) begin
      th  = s + cDead;
      len = (th >= h) ? 0 : h - th;
      val = (len > 0) && (len >= cMin) && (c >= th);
      chop = cChopHi;
    end else begin
      val = (s > 0) && (s >= cMin) && (c < s);
      chop = cChopLo;
    end
    if (chop && ((k % span) >= cDiv + 1)) val = 0;
    return val && cMask[j];
  endfunction

  task automatic pushExpected(string tag);
    expItem_t it;
    int h;
    h = (cH == 0) ? 1 : cH;
    it.tag = tag;
    it.len = 2 * h;
    for (int j = 0; j < 6; j++) begin
      it.onCnt[j] = 0;
      it.firstOn[j] = -1;
      for (int k = 0; k < 2*h; k++) begin
        if (refOn(j, k)) begin
          it.onCnt[j]++;
          if (it.firstOn[j] < 0) it.firstOn[j] = k;
        end
      end
    end
    expQ.push_back(it);
  endtask

  // Monitor: measures each period between sync pulses
  initial begin
    expItem_t cur;
    int k = 0;
    bit armed = 0;
    int mOn[6], mFirst[6];
    forever begin
      @(negedge clk);
      if (!rstN) armed = 0;
      else begin
        if (syncOut) begin
          if (armed) begin
            check(k == cur.len, "R2", {cur.tag, " period length"}, k, cur.len);
            for (int j = 0; j < 6; j++) begin
              check(mOn[j] == cur.onCnt[j], cur.tag, $sformatf("out%0d on-count", j),
                    mOn[j], cur.onCnt[j]);
              check(mFirst[j] == cur.firstOn[j], cur.tag, $sformatf("out%0d first-on", j),
                    mFirst[j], cur.firstOn[j]);
            end
            doneCnt++;
          end
          if (expQ.size() > 0) begin
            cur = expQ.pop_front();
            armed = 1;
            k = 0;
            for (int j = 0; j < 6; j++) begin mOn[j] = 0; mFirst[j] = -1; end
          end else armed = 0;
        end
        if (armed) begin
          for (int j = 0; j < 6; j++) begin
            if (gateOut[j] == polHigh) begin
              mOn[j]++;
              if (mFirst[j] < 0) mFirst[j] = k;
            end
          end
          k++;
        end
      end
    end
  end

  task automatic wr(logic [3:0] a, int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = 16'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitSync();
    do @(negedge clk); while (!syncOut);
  endtask

  task automatic waitDone(int target);
    while (doneCnt < target) @(negedge clk);
  endtask

  task automatic setDuty(int a, int b, int c);
    wr(4'd1, a); wr(4'd2, b); wr(4'd3, c);
    dUp[0] = a; dUp[1] = b; dUp[2] = c;
    dDn[0] = a; dDn[1] = b; dDn[2] = c;
  endtask

  task automatic runItem(string tag);
    int target;
    waitSync();
    @(posedge clk);
    pushExpected(tag);
    target = doneCnt + 1;
    waitDone(target);
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", "run did not finish", 0, 1);
    finishRun();
  end

  initial begin
    int target, anyOn;
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0; tripN = 1'b1; polHigh = 1'b1;
    repeat (4) @(negedge clk);
    // R1: outputs inactive and no sync while in reset
    check(gateOut == 6'h00, "R1", "gates in reset", gateOut, 0);
    check(syncOut == 1'b0, "R1", "sync in reset", syncOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(syncOut == 1'b1, "R1", "first sync after reset", syncOut, 1);
    check(gateOut == 6'h00, "R1", "gates after reset", gateOut, 0);

    // R3 R4 R5: basic waveform
    wr(4'd0, 20); cH = 20;
    wr(4'd4, 2);  cDead = 2;
    wr(4'd5, 0);  cMin = 0;
    wr(4'd8, 'h3F); cMask = 6'h3F;
    setDuty(10, 15, 3);
    runItem("R3 R4 R5 basic");

    // R3 R4: duty above, at and at zero
    setDuty(25, 0, 20);
    runItem("R3 R4 clip");

    // R6: narrow pulses deleted
    wr(4'd5, 4); cMin = 4;
    setDuty(10, 17, 3);
    runItem("R6 deletion");
    wr(4'd5, 0); cMin = 0;

    // R9: enable mask
    setDuty(10, 12, 6);
    wr(4'd8, 'b100110); cMask = 6'b100110;
    runItem("R9 mask");
    wr(4'd8, 'h3F); cMask = 6'h3F;

    // R10: active-low polarity
    polHigh = 1'b0;
    runItem("R10 polarity");
    polHigh = 1'b1;

    // R13: chopping of high sides, then low sides
    wr(4'd7, 2); cDiv = 2;
    wr(4'd6, 2); cChopHi = 1;
    runItem("R13 chop high");
    wr(4'd6, 4); cChopHi = 0; cChopLo = 1;
    runItem("R13 chop low");
    wr(4'd6, 0); cChopLo = 0;

    // R2: zero half period treated as one
    wr(4'd4, 0); cDead = 0;
    wr(4'd0, 0); cH = 0;
    setDuty(1, 0, 1);
    runItem("R2 zero half");
    wr(4'd0, 20); cH = 20;
    wr(4'd4, 2);  cDead = 2;
    setDuty(10, 10, 10);
    runItem("R3 R4 settle");

    // R7: single-rate, write inside a period waits for the next start
    waitSync();
    @(posedge clk);
    pushExpected("R7 single rate");
    target = doneCnt + 1;
    waitSync();
    wr(4'd1, 16);
    waitDone(target);
    dUp[0] = 16; dDn[0] = 16;
    runItem("R7 after reload");

    // R8: double-rate, write inside rising half applies at midpoint
    wr(4'd6, 1);
    runItem("R8 settle");
    waitSync();
    @(posedge clk);
    dDn[0] = 6;
    pushExpected("R8 double rate");
    target = doneCnt + 1;
    waitSync();
    wr(4'd1, 6);
    waitDone(target);
    dUp[0] = 6;
    wr(4'd6, 0);

    // R11: trip blanks outputs without a clock edge
    repeat (7) @(negedge clk);
    tripN = 1'b0;
    #1;
    check(gateOut == 6'h00, "R11", "gates right after trip", gateOut, 0);
    wr(4'd9, 0);                       // clear attempt while trip still low
    repeat (3) @(negedge clk);
    tripN = 1'b1;
    anyOn = 0;
    for (int i = 0; i < 46; i++) begin
      @(negedge clk);
      if (gateOut != 6'h00) anyOn++;
    end
    check(anyOn == 0, "R12", "cycles with output on while latched", anyOn, 0);
    wr(4'd9, 0);
    runItem("R12 resume after clear");

    finishRun();
  end

endmodule